// File: doc/BRIEF.md
# Key-Unlocked Flash Program/Erase Controller

This block sits between a CPU register bus and a small on-chip flash array, which is modelled as a bank of registers inside the block. Before any program or erase, software sets a self-programming enable bit. It then unlocks the controller by writing a two-byte key. Next it loads a sector number and a word address. Writing the data register then programs one 16-bit word. Programming can only clear bits. To erase, software writes the erase-start register: with the erase-select bit set first this erases one sector, and without it this erases the whole array.

While a program or erase is running, the block holds the CPU stall output high for a fixed number of cycles, and software does not poll. After each completed command the controller locks itself again. A program or erase attempted while locked leaves the array unchanged and sets a sticky error flag. A read port returns array contents so that software can compare them after a write.

The key logic has three states. KS_LOCKED moves to KS_HALF on the first key byte. KS_HALF moves to KS_OPEN on the second key byte and back to KS_LOCKED on any other byte. KS_OPEN returns to KS_LOCKED on any key write, when a command completes, or when self-programming is disabled. The operation logic has three states. OP_IDLE moves to OP_PROG on a data write and to OP_ERASE on an erase start, in both cases only while unlocked. OP_PROG and OP_ERASE return to OP_IDLE when their cycle counter expires, and that is when the array is updated.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Register select 0 (bit 0) is the self-programming enable. While it is 0, key writes have no effect, so data writes and erase starts are refused and the array is unchanged.
- R2: Register select 1 takes a key byte in bits 7:0. The controller unlocks only after 0xFA followed directly by 0xF5. A wrong byte, including a repeated 0xFA, returns it to locked.
- R3: The target word is selected by register select 2 (sector number, bit 0) together with register select 3 (word in sector, bits 8:0). Each sector has 512 words and there are 2 sectors. The read port address is {sector, word}.
- R4: Writing register select 4 while unlocked and idle programs the addressed word. The new value is the old value AND the written data.
- R5: cpu_stall rises in the cycle after the starting write. It stays high for exactly 8 cycles for a program and exactly 64 cycles for an erase.
- R6: Writing 1 to register select 5 (bit 0) and then 1 to register select 6 (bit 0) erases only the selected sector to 0xFFFF. The other sector is untouched.
- R7: Writing 1 to register select 6 with erase-select at 0 erases every word of the array to 0xFFFF.
- R8: After reset, cpu_stall and lock_err are 0 and every word reads 0xFFFF.
- R9: After each completed program or erase, the controller is locked again. A following command without a new key sequence is refused.
- R10: A data write, or an erase-start write of 1, while locked leaves the array unchanged, causes no stall, and sets lock_err. lock_err stays set until reset.
- R11: Writing 0 to the enable bit relocks the controller. Setting the enable bit again does not restore the unlock.
- R12: arr_rdata returns the word at arr_raddr one clock after arr_raddr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| arr_raddr | input | 10 | Array read address {sector, word} |
| arr_rdata | output | 16 | Array read data, one cycle after the address |
| cpu_stall | output | 1 | High while a program or erase is running |
| lock_err | output | 1 | Sticky flag for a command refused while locked |

## Verification
Each register write lands on one rising edge, and its effect is sampled on the following falling edge. cpu_stall is therefore already high at the first sample after a data or erase-start write. The bench counts falling-edge samples while the stall stays high and expects 8 or 64 of them. Array updates take effect on the edge that ends the stall. Read data is one registered stage behind the read address, so the bench presents an address, waits one full cycle, and samples on the next falling edge. Refused commands are checked by requiring zero stall samples, an unchanged array word at the target address and the state of lock_err.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_KEY   = 3'd1,
        SEL_SECT  = 3'd2,
        SEL_WADDR = 3'd3,
        SEL_DATA  = 3'd4,
        SEL_ESEL  = 3'd5,
        SEL_EGO   = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hFA;
    localparam logic [7:0] KEY_SECOND = 8'hF5;

endpackage

// File: rtl/fpe_key_fsm.sv
module fpe_key_fsm
    import flash_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enabled,
    input  logic       disarm,
    input  logic       relock,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlocked
);

    key_state_e state_q;
    key_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (disarm || relock) begin
            state_d = KS_LOCKED;
        end else if (key_wr && enabled) begin
            unique case (state_q)
                KS_LOCKED: state_d = (key_byte == KEY_FIRST)  ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_d = (key_byte == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   state_d = KS_LOCKED;
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unlocked = (state_q == KS_OPEN);
    end

endmodule

// File: rtl/fpe_op_timer.sv
module fpe_op_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
    parameter int DATA_W       = 16,
    parameter int SECTORS      = 2,
    parameter int SECTOR_WORDS = 512,
    parameter int SECT_W       = 1,
    parameter int ADDR_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic              erase_all,
    input  logic [SECT_W-1:0] erase_sect,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = SECTORS * SECTOR_WORDS;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(w / SECTOR_WORDS);
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(w);

        logic [DATA_W-1:0] cell_q;
        logic              hit_erase;
        logic              hit_prog;

        assign hit_erase = erase_en && (erase_all || (erase_sect == MY_SECT));
        assign hit_prog  = prog_en && (prog_addr == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (hit_erase) begin
                cell_q <= '1;
            end else if (hit_prog) begin
                cell_q <= cell_q & prog_data;
            end
        end

        assign words[w] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '1;
        end else begin
            rdata <= words[raddr];
        end
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SECTORS      = 2,
    parameter int SECTOR_WORDS = 512,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    input  logic [9:0]  arr_raddr,
    output logic [15:0] arr_rdata,
    output logic        cpu_stall,
    output logic        lock_err
);

    localparam int WORD_AW = $clog2(SECTOR_WORDS);
    localparam int SECT_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1;
    localparam int ADDR_W  = SECT_W + WORD_AW;
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    // software-visible configuration
    logic              enable_q;
    logic [SECT_W-1:0] sect_q;
    logic [WORD_AW-1:0] waddr_q;
    logic [DATA_W-1:0] data_q;
    logic              esel_q;
    logic              erase_all_q;
    logic              err_q;

    op_state_e op_q;
    op_state_e op_d;

    logic key_open;
    logic busy;
    logic wr_ok;
    logic want_prog;
    logic want_erase;
    logic timer_last;
    logic timer_start;
    logic [CNT_W-1:0] timer_load;
    logic prog_commit;
    logic erase_commit;
    logic relock;
    logic disarm;

    assign busy       = (op_q != OP_IDLE);
    assign wr_ok      = reg_wr && !busy;
    assign want_prog  = wr_ok && (sel == SEL_DATA);
    assign want_erase = wr_ok && (sel == SEL_EGO) && reg_wdata[0];
    assign disarm     = (wr_ok && (sel == SEL_CTRL) && !reg_wdata[0]) || !enable_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            sect_q   <= '0;
            waddr_q  <= '0;
            data_q   <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_CTRL:  enable_q <= reg_wdata[0];
                SEL_SECT:  sect_q   <= reg_wdata[SECT_W-1:0];
                SEL_WADDR: waddr_q  <= reg_wdata[WORD_AW-1:0];
                SEL_DATA:  data_q   <= reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // erase select is consumed by the erase it qualifies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esel_q <= 1'b0;
        end else if (erase_commit) begin
            esel_q <= 1'b0;
        end else if (wr_ok && (sel == SEL_ESEL)) begin
            esel_q <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_all_q <= 1'b0;
        end else if (op_q == OP_IDLE && want_erase && key_open) begin
            erase_all_q <= !esel_q;
        end
    end

    // sticky refusal flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((want_prog || want_erase) && !key_open) begin
            err_q <= 1'b1;
        end
    end

    // operation state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= op_d;
        end
    end

    // operation transitions
    always_comb begin
        op_d = op_q;
        unique case (op_q)
            OP_IDLE: begin
                if (want_prog && key_open) begin
                    op_d = OP_PROG;
                end else if (want_erase && key_open) begin
                    op_d = OP_ERASE;
                end
            end
            OP_PROG:  if (timer_last) op_d = OP_IDLE;
            OP_ERASE: if (timer_last) op_d = OP_IDLE;
            default:  op_d = OP_IDLE;
        endcase
    end

    // operation outputs
    always_comb begin
        timer_start  = 1'b0;
        timer_load   = PROG_LOAD;
        prog_commit  = 1'b0;
        erase_commit = 1'b0;
        unique case (op_q)
            OP_IDLE: begin
                if (want_prog && key_open) begin
                    timer_start = 1'b1;
                    timer_load  = PROG_LOAD;
                end else if (want_erase && key_open) begin
                    timer_start = 1'b1;
                    timer_load  = ERASE_LOAD;
                end
            end
            OP_PROG:  prog_commit  = timer_last;
            OP_ERASE: erase_commit = timer_last;
            default: ;
        endcase
        relock    = prog_commit || erase_commit;
        cpu_stall = busy;
        lock_err  = err_q;
    end

    fpe_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .enabled  (enable_q),
        .disarm   (disarm),
        .relock   (relock),
        .key_wr   (wr_ok && (sel == SEL_KEY)),
        .key_byte (reg_wdata[7:0]),
        .unlocked (key_open)
    );

    fpe_op_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .load  (timer_load),
        .last  (timer_last)
    );

    fpe_array #(
        .DATA_W       (DATA_W),
        .SECTORS      (SECTORS),
        .SECTOR_WORDS (SECTOR_WORDS),
        .SECT_W       (SECT_W),
        .ADDR_W       (ADDR_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_commit),
        .prog_addr  ({sect_q, waddr_q}),
        .prog_data  (data_q),
        .erase_en   (erase_commit),
        .erase_all  (erase_all_q),
        .erase_sect (sect_q),
        .raddr      (arr_raddr[ADDR_W-1:0]),
        .rdata      (arr_rdata[DATA_W-1:0])
    );

endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
    parameter int MAX_RUN = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_sel,
    input logic [7:0] key_byte,
    input logic       cpu_stall,
    input logic       lock_err,
    input logic       unlocked,
    input logic       enable
);

    logic [31:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (cpu_stall) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= '0;
        end
    end

    a_r1_open_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> enable);

    a_r2_open_after_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(reg_wr && reg_sel == 3'd1 && key_byte == 8'hF5));

    a_r4_data_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd4 && unlocked && !cpu_stall) |=> cpu_stall);

    a_r5_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (run_cnt < MAX_RUN));

    a_r9_locked_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> !unlocked);

    a_r10_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !cpu_stall) |=> !cpu_stall);

    a_r10_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd4 && !unlocked && !cpu_stall) |=> lock_err);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

endmodule

bind flash_pe_ctrl fpe_checker #(
    .MAX_RUN (ERASE_CYCLES)
) u_fpe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .key_byte  (reg_wdata[7:0]),
    .cpu_stall (cpu_stall),
    .lock_err  (lock_err),
    .unlocked  (key_open),
    .enable    (enable_q)
);

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd7;
    logic [15:0] reg_wdata = '0;
    logic [9:0]  arr_raddr = '0;
    logic [15:0] arr_rdata;
    logic        cpu_stall;
    logic        lock_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    flash_pe_ctrl i_flash_pe_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .arr_raddr (arr_raddr),
        .arr_rdata (arr_rdata),
        .cpu_stall (cpu_stall),
        .lock_err  (lock_err)
    );

    // {sector(4), word(12), data(16), expected(16)}
    localparam logic [47:0] VEC [6] = '{
        48'h0_000_1234_1234,
        48'h0_000_FF00_1200,
        48'h1_1FF_A5A5_A5A5,
        48'h0_1FF_0F0F_0F0F,
        48'h1_000_0000_0000,
        48'h0_001_8001_8001
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_sel   = 3'd7;
    endtask

    task automatic unlock();
        wr(3'd1, 16'h00FA);
        wr(3'd1, 16'h00F5);
    endtask

    task automatic rd(input logic [9:0] a, output logic [15:0] v);
        @(negedge clk);
        arr_raddr = a;
        @(negedge clk);
        v = arr_rdata;
    endtask

    task automatic stall_len(output int n);
        n = 0;
        while (cpu_stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 stall after reset", 32'(cpu_stall), 32'd0);
        chk("R8 err after reset", 32'(lock_err), 32'd0);
        rd({1'b0, 9'd0}, v);
        chk("R8 s0w0 erased", 32'(v), 32'hFFFF);
        rd({1'b1, 9'd511}, v);
        chk("R8 s1w511 erased", 32'(v), 32'hFFFF);

        wr(3'd0, 16'h0001);

        // R3 R4 R5 R12 program table
        for (int i = 0; i < 6; i++) begin
            logic [47:0] e;
            e = VEC[i];
            unlock();
            wr(3'd2, {12'd0, e[47:44]});
            wr(3'd3, {4'd0, e[43:32]});
            wr(3'd4, e[31:16]);
            stall_len(n);
            chk("R5 program stall length", 32'(n), 32'd8);
            rd({e[44], e[40:32]}, v);
            chk("R4 R3 R12 programmed word", 32'(v), 32'(e[15:0]));
        end
        chk("R4 no error on legal programs", 32'(lock_err), 32'd0);
        rd({1'b0, 9'd0}, v);
        chk("R3 earlier word kept", 32'(v), 32'h1200);

        // R9 R10 command without fresh key after a completed program
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0001);
        wr(3'd4, 16'h0000);
        stall_len(n);
        chk("R9 no stall when relocked", 32'(n), 32'd0);
        chk("R10 err set on locked write", 32'(lock_err), 32'd1);
        rd({1'b0, 9'd1}, v);
        chk("R10 array unchanged", 32'(v), 32'h8001);

        // R10 locked erase start refused
        wr(3'd6, 16'h0001);
        stall_len(n);
        chk("R10 no stall on locked erase", 32'(n), 32'd0);
        rd({1'b1, 9'd511}, v);
        chk("R10 array unchanged after erase try", 32'(v), 32'hA5A5);
        chk("R10 err stays set", 32'(lock_err), 32'd1);

        // R2 wrong key order
        wr(3'd1, 16'h00FA);
        wr(3'd1, 16'h00FA);
        wr(3'd1, 16'h00F5);
        wr(3'd4, 16'h0000);
        stall_len(n);
        chk("R2 wrong order no stall", 32'(n), 32'd0);
        rd({1'b0, 9'd1}, v);
        chk("R2 wrong order array unchanged", 32'(v), 32'h8001);
        wr(3'd1, 16'h00F5);
        wr(3'd1, 16'h00FA);
        wr(3'd4, 16'h0000);
        stall_len(n);
        chk("R2 reversed key no stall", 32'(n), 32'd0);

        // R1 enable cleared
        wr(3'd0, 16'h0000);
        unlock();
        wr(3'd4, 16'h0000);
        stall_len(n);
        chk("R1 disabled no stall", 32'(n), 32'd0);
        rd({1'b0, 9'd1}, v);
        chk("R1 disabled array unchanged", 32'(v), 32'h8001);

        // R11 disable after unlock
        wr(3'd0, 16'h0001);
        unlock();
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0001);
        wr(3'd4, 16'h0000);
        stall_len(n);
        chk("R11 relocked no stall", 32'(n), 32'd0);
        rd({1'b0, 9'd1}, v);
        chk("R11 array unchanged", 32'(v), 32'h8001);

        // R6 sector erase of sector 0
        unlock();
        wr(3'd2, 16'h0000);
        wr(3'd5, 16'h0001);
        wr(3'd6, 16'h0001);
        stall_len(n);
        chk("R5 erase stall length", 32'(n), 32'd64);
        rd({1'b0, 9'd0}, v);
        chk("R6 sector0 w0 erased", 32'(v), 32'hFFFF);
        rd({1'b0, 9'd511}, v);
        chk("R6 sector0 w511 erased", 32'(v), 32'hFFFF);
        rd({1'b1, 9'd511}, v);
        chk("R6 sector1 kept", 32'(v), 32'hA5A5);
        rd({1'b1, 9'd0}, v);
        chk("R6 sector1 w0 kept", 32'(v), 32'h0000);

        // R9 erase also relocks
        wr(3'd6, 16'h0001);
        stall_len(n);
        chk("R9 no erase without new key", 32'(n), 32'd0);

        // R7 block erase
        unlock();
        wr(3'd2, 16'h0000);
        wr(3'd6, 16'h0001);
        stall_len(n);
        chk("R7 block erase stall", 32'(n), 32'd64);
        rd({1'b1, 9'd511}, v);
        chk("R7 sector1 w511 erased", 32'(v), 32'hFFFF);
        rd({1'b1, 9'd0}, v);
        chk("R7 sector1 w0 erased", 32'(v), 32'hFFFF);

        summary();
        $finish;
    end

endmodule